// File: doc/BRIEF.md
# Handshaked Register UART

This block is a byte-wide serial port mapped onto a two-word register bus. Word 0 carries the character together with two handshake bits. Software polls the receive-valid bit and releases a received byte by writing a one to that bit. It polls the transmit-ready bit and queues a character by writing it with the ready bit set. No read has side effects. Word 1 holds the configuration: parity, interface mode, flow and override fields. It also reports break, interrupt and busy state.

The core has no baud generator of its own. A bit tick paces the transmitter: each tick starts one bit time. An oversampling tick, sixteen per bit, paces the receiver. Frames carry eight data bits, sent least significant bit first. They have one start bit, one stop bit and an optional parity bit. Each direction holds a single byte.

Top module: `uart_hs_core`

## Requirements
- R1: After reset every control field reads 0. While the interface mode (control bits 3:2) is 0, the transmit-ready bit reads 0, a queue write is ignored and the receiver ignores the line. Any nonzero mode enables the port, and txd_o idles high.
- R2: Data word (address 0): bits 7:0 hold the character and bit 8 reads 1 while a received byte waits. Writing 1 to bit 8 releases the byte and clears bit 8.
- R3: Data word bit 9 reads 1 while the transmit holding register is empty and the port is enabled. A write to word 0 with bit 9 set queues bits 7:0. The frame then goes out as a 0 start bit, the data LSB first and a 1 stop bit, with one bit per bit-tick period.
- R4: Control bits 1:0 select parity: 0 none, 2 odd, 3 even. Value 1 acts as none. With parity on, the parity bit follows the data bits, so that the count of ones over data and parity is odd (odd mode) or even (even mode).
- R5: A received frame whose parity bit is wrong is discarded, and bit 8 stays 0.
- R6: A byte that completes while bit 8 is still 1 is dropped. The held character and bit 8 are kept.
- R7: The receiver samples each bit at the eighth oversampling tick. A start bit that reads high at that point is rejected, and no byte is produced.
- R8: A frame whose data bits are all 0 and whose stop position is low sets the break flag, control bit 10, and delivers no byte. The receiver then waits for the line to go high. Writing 1 to bit 10 clears the flag. A zero byte with a high stop bit is a normal byte.
- R9: While control bit 11 is 1, txd_o is held low. Clearing it returns the line to its normal level.
- R10: Control bit 14 reads 1 while a transmit frame is in progress. Bit 15 reads 1 while the receiver is inside a frame.
- R11: Control bit 12 reads 1 while a received byte is valid or the transmitter is ready. irq_o equals bit 12 when enable bit 13 is 1 and is 0 otherwise.
- R12: Control bits 4, 5, 7 and 8 are stored and read back, and they have no effect on the line. Bit 9 of the control word mirrors transmit-ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_tick_i | input | 1 | One-cycle pulse per bit time, paces the transmitter |
| os_tick_i | input | 1 | One-cycle pulse at 16x bit rate, paces the receiver |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 for a write, 0 for a read |
| bus_addr_i | input | 1 | 0 selects the data word, 1 the control word |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, combinational, 0 when not selected |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line |
| irq_o | output | 1 | Host interrupt |

## Verification
The bench targets the points where the receiver must refuse data. It drives a start glitch shorter than half a bit, a frame with the wrong parity bit, a second byte sent before the first is released, and a long low line. Each of these must leave the data word unchanged. A design that samples too early, ignores parity or overwrites the held byte shows a stray or altered character. A receiver that re-arms during a break delivers junk bytes when the line rises. A frame of all zero data with a good stop bit must still arrive, so that break detection that ignores the stop bit is caught. On the transmit side, every frame is captured bit by bit under each parity mode. The disabled mode, the break override and the interrupt enable are each checked at the pins.

// File: rtl/uart_hs_pkg.sv
package uart_hs_pkg;
  localparam int REG_W    = 16;
  localparam int CHAR_W   = 8;
  // data word flag positions
  localparam int D_RXV    = 8;
  localparam int D_TXR    = 9;
  // control word positions
  localparam int C_RXBRK  = 10;
  localparam int C_TXBRK  = 11;
  localparam int C_IRQ    = 12;
  localparam int C_IE     = 13;

  typedef enum logic [2:0] {
    TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP
  } tx_st_e;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_HOLD
  } rx_st_e;
endpackage

// File: rtl/uart_hs_sync.sv
module uart_hs_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q[g] <= RST_VAL;
        else         ff_q[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q[g] <= RST_VAL;
        else         ff_q[g] <= ff_q[g-1];
    end
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/uart_hs_tx.sv
module uart_hs_tx
  import uart_hs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_tick_i,
  input  logic              en_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ready_o,
  output logic              busy_o,
  output logic              line_o
);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  tx_st_e            state_q;
  logic [DATA_W-1:0] hold_q, shift_q;
  logic              hold_full_q, par_q, par_en_q;
  logic [IDX_W-1:0]  idx_q;
  logic              launch;

  assign ready_o = en_i & ~hold_full_q;
  assign busy_o  = (state_q != TX_IDLE);
  // next frame starts on a tick from idle or straight out of a stop bit
  assign launch  = bit_tick_i & hold_full_q & en_i &
                   ((state_q == TX_IDLE) | (state_q == TX_STOP));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= TX_IDLE;
      hold_q      <= '0;
      shift_q     <= '0;
      hold_full_q <= 1'b0;
      par_q       <= 1'b0;
      par_en_q    <= 1'b0;
      idx_q       <= '0;
    end else begin
      if (load_i && ready_o) begin
        hold_q      <= data_i;
        hold_full_q <= 1'b1;
      end
      if (launch) begin
        state_q     <= TX_START;
        shift_q     <= hold_q;
        par_q       <= (^hold_q) ^ par_odd_i;
        par_en_q    <= par_en_i;
        hold_full_q <= 1'b0;
      end else if (bit_tick_i) begin
        unique case (state_q)
          TX_START: begin
            state_q <= TX_DATA;
            idx_q   <= '0;
          end
          TX_DATA: begin
            shift_q <= shift_q >> 1;
            if (idx_q == LAST_IDX) state_q <= par_en_q ? TX_PAR : TX_STOP;
            else                   idx_q   <= idx_q + 1'b1;
          end
          TX_PAR:  state_q <= TX_STOP;
          TX_STOP: state_q <= TX_IDLE;
          default: state_q <= TX_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    unique case (state_q)
      TX_START: line_o = 1'b0;
      TX_DATA:  line_o = shift_q[0];
      TX_PAR:   line_o = par_q;
      default:  line_o = 1'b1;
    endcase
  end

  // R3: an accepted byte occupies the holding register on the next cycle
  a_r3_hold_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && ready_o |=> !ready_o);

  // R3: a frame always begins with the start level
  a_r3_start_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !line_o);
endmodule

// File: rtl/uart_hs_rx.sv
module uart_hs_rx
  import uart_hs_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int OS_RATE = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              os_tick_i,
  input  logic              en_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              rxd_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_vld_o,
  output logic              brk_o
);
  localparam int OS_W  = $clog2(OS_RATE);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [OS_W-1:0]  MID      = OS_W'(OS_RATE / 2 - 1);
  localparam logic [OS_W-1:0]  LAST     = OS_W'(OS_RATE - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  rx_st_e            state_q;
  logic [OS_W-1:0]   cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] shift_q;
  logic              acc_q, perr_q, par_en_q, par_odd_q;
  logic              vld_q, brk_q;
  logic              sample, bit_end, framing;

  assign framing = (state_q != RX_IDLE) & (state_q != RX_HOLD);
  assign sample  = os_tick_i & (cnt_q == MID);
  assign bit_end = os_tick_i & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= RX_IDLE;
      cnt_q     <= '0;
      idx_q     <= '0;
      shift_q   <= '0;
      acc_q     <= 1'b0;
      perr_q    <= 1'b0;
      par_en_q  <= 1'b0;
      par_odd_q <= 1'b0;
      vld_q     <= 1'b0;
      brk_q     <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      brk_q <= 1'b0;
      if (os_tick_i && framing) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      unique case (state_q)
        RX_IDLE: if (en_i && os_tick_i && !rxd_i) begin
          state_q   <= RX_START;
          cnt_q     <= '0;
          idx_q     <= '0;
          acc_q     <= 1'b0;
          perr_q    <= 1'b0;
          par_en_q  <= par_en_i;
          par_odd_q <= par_odd_i;
        end
        RX_START: begin
          if (sample && rxd_i) state_q <= RX_IDLE;
          else if (bit_end)    state_q <= RX_DATA;
        end
        RX_DATA: begin
          if (sample) begin
            shift_q <= {rxd_i, shift_q[DATA_W-1:1]};
            acc_q   <= acc_q ^ rxd_i;
          end
          if (bit_end) begin
            if (idx_q == LAST_IDX) state_q <= par_en_q ? RX_PAR : RX_STOP;
            else                   idx_q   <= idx_q + 1'b1;
          end
        end
        RX_PAR: begin
          if (sample)  perr_q  <= ((acc_q ^ rxd_i) != par_odd_q);
          if (bit_end) state_q <= RX_STOP;
        end
        RX_STOP: if (sample) begin
          if (rxd_i) begin
            vld_q   <= ~perr_q;
            state_q <= RX_IDLE;
          end else if (shift_q == '0) begin
            brk_q   <= 1'b1;
            state_q <= RX_HOLD;
          end else begin
            state_q <= RX_IDLE;
          end
        end
        RX_HOLD: if (rxd_i) state_q <= RX_IDLE;
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != RX_IDLE);
  assign data_o     = shift_q;
  assign data_vld_o = vld_q;
  assign brk_o      = brk_q;

  // R7: a start bit seen high at mid-bit aborts the frame
  a_r7_false_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RX_START) && sample && rxd_i |=> (state_q == RX_IDLE));

  // R8: after a break nothing is accepted until the line is high
  a_r8_break_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RX_HOLD) && !rxd_i |=> (state_q == RX_HOLD) && !data_vld_o);
endmodule

// File: rtl/uart_hs_core.sv
module uart_hs_core
  import uart_hs_pkg::*;
#(
  parameter int OS_RATE     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_tick_i,
  input  logic             os_tick_i,
  input  logic             bus_sel_i,
  input  logic             bus_we_i,
  input  logic             bus_addr_i,
  input  logic [REG_W-1:0] bus_wdata_i,
  output logic [REG_W-1:0] bus_rdata_o,
  input  logic             rxd_i,
  output logic             txd_o,
  output logic             irq_o
);
  logic [1:0]        par_mode_q, if_mode_q, flow_q;
  logic              rx_ovr_q, tx_ovr_q, rx_brk_q, tx_brk_q, ie_q;
  logic              rx_valid_q;
  logic [CHAR_W-1:0] rx_byte_q;

  logic              wr_data, wr_ctrl, port_en, par_en, par_odd;
  logic              tx_ready, tx_busy, tx_line;
  logic              rx_busy, rx_vld, rx_brk, rxd_s;
  logic [CHAR_W-1:0] rx_data;
  logic              int_flag;
  logic              unused_wbits;

  assign wr_data = bus_sel_i & bus_we_i & ~bus_addr_i;
  assign wr_ctrl = bus_sel_i & bus_we_i &  bus_addr_i;
  assign port_en = |if_mode_q;
  assign par_en  = par_mode_q[1];
  assign par_odd = ~par_mode_q[0];
  assign unused_wbits = ^{bus_wdata_i[15:14], bus_wdata_i[12], bus_wdata_i[6]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      par_mode_q <= '0;
      if_mode_q  <= '0;
      flow_q     <= '0;
      rx_ovr_q   <= 1'b0;
      tx_ovr_q   <= 1'b0;
      tx_brk_q   <= 1'b0;
      ie_q       <= 1'b0;
    end else if (wr_ctrl) begin
      par_mode_q <= bus_wdata_i[1:0];
      if_mode_q  <= bus_wdata_i[3:2];
      flow_q     <= bus_wdata_i[5:4];
      rx_ovr_q   <= bus_wdata_i[7];
      tx_ovr_q   <= bus_wdata_i[8];
      tx_brk_q   <= bus_wdata_i[C_TXBRK];
      ie_q       <= bus_wdata_i[C_IE];
    end
  end

  // break flag: set by receiver, write-one-clear, set wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             rx_brk_q <= 1'b0;
    else if (rx_brk)                         rx_brk_q <= 1'b1;
    else if (wr_ctrl && bus_wdata_i[C_RXBRK]) rx_brk_q <= 1'b0;
  end

  // receive holding register; a byte arriving while full is dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_valid_q <= 1'b0;
      rx_byte_q  <= '0;
    end else if (wr_data && bus_wdata_i[D_RXV]) begin
      rx_valid_q <= 1'b0;
    end else if (rx_vld && !rx_valid_q) begin
      rx_valid_q <= 1'b1;
      rx_byte_q  <= rx_data;
    end
  end

  uart_hs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (rxd_i),
    .q_o    (rxd_s)
  );

  uart_hs_tx #(.DATA_W(CHAR_W)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_tick_i (bit_tick_i),
    .en_i       (port_en),
    .par_en_i   (par_en),
    .par_odd_i  (par_odd),
    .load_i     (wr_data & bus_wdata_i[D_TXR]),
    .data_i     (bus_wdata_i[CHAR_W-1:0]),
    .ready_o    (tx_ready),
    .busy_o     (tx_busy),
    .line_o     (tx_line)
  );

  uart_hs_rx #(.DATA_W(CHAR_W), .OS_RATE(OS_RATE)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .os_tick_i  (os_tick_i),
    .en_i       (port_en),
    .par_en_i   (par_en),
    .par_odd_i  (par_odd),
    .rxd_i      (rxd_s),
    .busy_o     (rx_busy),
    .data_o     (rx_data),
    .data_vld_o (rx_vld),
    .brk_o      (rx_brk)
  );

  assign int_flag = rx_valid_q | tx_ready;
  assign irq_o    = int_flag & ie_q;
  assign txd_o    = tx_line & ~tx_brk_q;

  always_comb begin
    bus_rdata_o = '0;
    if (bus_sel_i) begin
      if (!bus_addr_i) begin
        bus_rdata_o[CHAR_W-1:0] = rx_byte_q;
        bus_rdata_o[D_RXV]      = rx_valid_q;
        bus_rdata_o[D_TXR]      = tx_ready;
      end else begin
        bus_rdata_o = {rx_busy, tx_busy, ie_q, int_flag, tx_brk_q, rx_brk_q,
                       tx_ready, tx_ovr_q, rx_ovr_q, 1'b0, flow_q, if_mode_q,
                       par_mode_q};
      end
    end
  end

  // R6: a held byte survives until software releases it
  a_r6_hold_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_q && !(wr_data && bus_wdata_i[D_RXV]) |=> rx_valid_q && $stable(rx_byte_q));

  // R9: break request dominates the line
  a_r9_break_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_brk_q |-> !txd_o);

  // R1: a disabled port never starts a frame
  a_r1_off_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_en && !tx_busy |=> !tx_busy);
endmodule

// File: tb/uart_hs_core_tb.sv
module uart_hs_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_CYC    = 64;
  localparam int OS_CYC     = 4;
  localparam int WDOG       = 150000;
  localparam int NVEC       = 6;
  // {parity mode, character}
  localparam logic [9:0] VEC [NVEC] = '{
    {2'd0, 8'h55}, {2'd2, 8'hA3}, {2'd3, 8'hA3},
    {2'd2, 8'h00}, {2'd3, 8'hFF}, {2'd0, 8'h81}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bit_tick = 1'b0, os_tick = 1'b0;
  logic        sel = 1'b0, we = 1'b0, addr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rxd = 1'b1;
  logic        txd, irq;
  int          n_chk = 0, n_fail = 0;

  uart_hs_core u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bit_tick_i  (bit_tick),
    .os_tick_i   (os_tick),
    .bus_sel_i   (sel),
    .bus_we_i    (we),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .rxd_i       (rxd),
    .txd_o       (txd),
    .irq_o       (irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    int tcnt = 0;
    forever begin
      @(negedge clk);
      tcnt     = (tcnt + 1) % BIT_CYC;
      os_tick  = (tcnt % OS_CYC == 0);
      bit_tick = (tcnt == 0);
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [15:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic bus_read(input logic a, output logic [15:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  task automatic line_bits(input logic v, input int nbits);
    rxd = v;
    repeat (nbits * BIT_CYC) @(negedge clk);
  endtask

  function automatic logic par_of(input logic [1:0] mode, input logic [7:0] d);
    return (^d) ^ ~mode[0];
  endfunction

  task automatic rx_frame(input logic [7:0] d, input logic use_par, input logic pbit);
    line_bits(1'b0, 1);
    for (int i = 0; i < 8; i++) line_bits(d[i], 1);
    if (use_par) line_bits(pbit, 1);
    line_bits(1'b1, 1);
  endtask

  task automatic tx_capture(input logic use_par, output logic [7:0] d,
                            output logic p, output logic ok);
    int w = 0;
    ok = 1'b1; d = '0; p = 1'b0;
    while (txd !== 1'b0 && w < 300) begin @(negedge clk); w++; end
    if (w >= 300) ok = 1'b0;
    repeat (BIT_CYC/2) @(negedge clk);
    if (txd !== 1'b0) ok = 1'b0;
    for (int i = 0; i < 8; i++) begin
      repeat (BIT_CYC) @(negedge clk);
      d[i] = txd;
    end
    if (use_par) begin
      repeat (BIT_CYC) @(negedge clk);
      p = txd;
    end
    repeat (BIT_CYC) @(negedge clk);
    if (txd !== 1'b1) ok = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog all actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [15:0] r;
    logic [7:0]  cap;
    logic        cp, ok;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state, port disabled
    bus_read(1'b0, r); check("R1 reset data", r, 16'h0000);
    bus_read(1'b1, r); check("R1 reset ctrl", r, 16'h0000);
    check("R1 reset txd/irq", {14'd0, txd, irq}, 16'h0002);
    bus_write(1'b0, 16'h0241);
    rx_frame(8'h5A, 1'b0, 1'b0);
    repeat (2 * BIT_CYC) @(negedge clk);
    bus_read(1'b0, r); check("R1 disabled ignores rx and tx", r, 16'h0000);
    check("R1 disabled txd idle", {15'd0, txd}, 16'h0001);

    // R2 R3 R4 table walk
    for (int v = 0; v < NVEC; v++) begin
      logic [1:0] pm;
      logic [7:0] ch;
      logic       pen;
      pm  = VEC[v][9:8];
      ch  = VEC[v][7:0];
      pen = pm[1];
      bus_write(1'b1, {12'h000, 2'b10, pm});
      rx_frame(ch, pen, par_of(pm, ch));
      repeat (8) @(negedge clk);
      bus_read(1'b0, r); check("R2 R4 rx byte valid", r, {8'h03, ch});
      bus_write(1'b0, 16'h0100);
      bus_read(1'b0, r); check("R2 release clears flag", r, {8'h02, ch});
      bus_write(1'b0, {8'h02, ch});
      tx_capture(pen, cap, cp, ok);
      check("R3 tx frame bits", {7'd0, ok, cap}, {8'h01, ch});
      if (pen) check("R4 tx parity bit", {15'd0, cp}, {15'd0, par_of(pm, ch)});
      repeat (BIT_CYC) @(negedge clk);
    end

    // R6 overrun: second byte dropped
    bus_write(1'b1, 16'h0008);
    rx_frame(8'h11, 1'b0, 1'b0);
    rx_frame(8'h22, 1'b0, 1'b0);
    repeat (8) @(negedge clk);
    bus_read(1'b0, r); check("R6 held byte kept", r, 16'h0311);
    bus_write(1'b0, 16'h0100);
    bus_read(1'b0, r); check("R6 released", r, 16'h0211);

    // R5 parity error, even mode, wrong parity bit
    bus_write(1'b1, 16'h000B);
    rx_frame(8'h0F, 1'b1, 1'b1);
    repeat (8) @(negedge clk);
    bus_read(1'b0, r); check("R5 bad parity discarded", r & 16'h0300, 16'h0200);

    // R7 short start glitch
    bus_write(1'b1, 16'h0008);
    rxd = 1'b0; repeat (12) @(negedge clk); rxd = 1'b1;
    repeat (2 * BIT_CYC) @(negedge clk);
    bus_read(1'b0, r); check("R7 glitch gives no byte", r & 16'h0300, 16'h0200);
    bus_read(1'b1, r); check("R7 R10 rx not busy", r & 16'h8000, 16'h0000);

    // R10 rx busy mid-frame; R8 zero byte with good stop is data
    rxd = 1'b0; repeat (2 * BIT_CYC) @(negedge clk);
    bus_read(1'b1, r); check("R10 rx busy in frame", r & 16'h8000, 16'h8000);
    repeat (7 * BIT_CYC) @(negedge clk);
    line_bits(1'b1, 1);
    repeat (8) @(negedge clk);
    bus_read(1'b0, r); check("R8 zero byte not break", r, 16'h0300);
    bus_read(1'b1, r); check("R8 no break flag", r & 16'h0400, 16'h0000);
    bus_write(1'b0, 16'h0100);

    // R8 break
    line_bits(1'b0, 12);
    line_bits(1'b1, 3);
    bus_read(1'b1, r); check("R8 break flagged", r & 16'h0400, 16'h0400);
    bus_read(1'b0, r); check("R8 break gives no byte", r & 16'h0100, 16'h0000);
    bus_write(1'b1, 16'h0408);
    bus_read(1'b1, r); check("R8 break cleared", r & 16'h0400, 16'h0000);

    // R9 tx break
    bus_write(1'b1, 16'h0808);
    repeat (2) @(negedge clk);
    check("R9 txd forced low", {15'd0, txd}, 16'h0000);
    bus_write(1'b1, 16'h0008);
    repeat (2) @(negedge clk);
    check("R9 txd released", {15'd0, txd}, 16'h0001);

    // R10 tx busy
    bus_write(1'b0, 16'h0241);
    repeat (BIT_CYC + 40) @(negedge clk);
    bus_read(1'b1, r); check("R10 tx busy, ready again", r & 16'h4200, 16'h4200);
    repeat (12 * BIT_CYC) @(negedge clk);
    bus_read(1'b1, r); check("R10 tx idle", r & 16'h4000, 16'h0000);

    // R11 interrupt gating
    bus_write(1'b1, 16'h2008);
    repeat (2) @(negedge clk);
    check("R11 irq enabled", {15'd0, irq}, 16'h0001);
    bus_write(1'b1, 16'h0008);
    repeat (2) @(negedge clk);
    check("R11 irq masked", {15'd0, irq}, 16'h0000);
    bus_read(1'b1, r); check("R11 flag visible", r & 16'h1000, 16'h1000);
    bus_write(1'b1, 16'h2000);
    repeat (2) @(negedge clk);
    check("R11 no source no irq", {15'd0, irq}, 16'h0000);

    // R12 stored fields
    bus_write(1'b1, 16'h01B8);
    bus_read(1'b1, r); check("R12 readback", r, 16'h13B8);
    check("R12 line unaffected", {15'd0, txd}, 16'h0001);

    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule